// File: doc/BRIEF.md
# MLP layer slice compute engine

This block evaluates one slice of a three-layer perceptron forward pass in signed Q8.8 fixed point. The network's hidden and output neurons are split evenly across `NSLICE` slices. This instance owns `NHID/NSLICE` hidden neurons, starting at global hidden index `SLICE_ID*NHID/NSLICE`, and it owns `NOUT/NSLICE` output neurons. A start pulse launches the hidden phase. In that phase each owned hidden neuron takes a multiply-accumulate pass over the complete input vector, plus a bias term, and its sum then goes through a sigmoid. Each hidden result is published on a strobe so that a transport outside the block can send it to the other slices.

After the last owned hidden neuron the engine parks. It resumes only when a synchronization input reports that every slice has finished its hidden layer. It then evaluates its owned output neurons over the full hidden vector. That vector holds this slice's own results together with values that other slices loaded through a dedicated write port. A one-cycle done pulse marks the moment the outputs become readable. The input vector is double buffered, so the next vector can be written while the current one is being processed.

Top module: `mlp_slice_engine`

## Requirements
- R1: A `start` pulse while idle begins the hidden phase with neuron 0, term 0. A `start` while busy is ignored: it neither restarts the pass nor swaps the input buffers.
- R2: Every neuron's sum begins with a bias term: weight slot k=0 is multiplied by a constant activity of 1.0 (256 in Q8.8). Hidden neuron h uses weight addresses h*(NIN+1)+k. Output neuron o uses OWN_H*(NIN+1)+o*(NHID+1)+k. For k>=1 the activity is input k-1, or hidden value k-1 for output neurons.
- R3: Each term adds (activity*weight)>>>8, an arithmetic shift that keeps Q8.8 scale, into a 24-bit signed sum. A hidden neuron performs NIN+1 terms, one per cycle.
- R4: The running sum saturates at +8388607 and -8388608 at every term instead of wrapping.
- R5: A neuron's result is computed once its last term is in, as follows. Clamp the sum to [-2048,2047] and take s = clamped>>>4, which lies in -128..127. The result is 128+(128*s)/(16+|s|), with the division truncating toward zero; this is a rational approximation of the logistic curve.
- R6: Each finished hidden neuron raises `hid_valid` for one cycle with its global index and value and stores it in the hidden vector. `hid_done` pulses together with the strobe of the last owned hidden neuron.
- R7: After the hidden phase the engine waits, with `busy` high, until `sync_go` is seen. A `sync_go` at any other time is ignored.
- R8: Output neuron o performs NHID+1 terms over the full hidden vector. That vector holds the values written through `h_we`/`h_addr`/`h_data` and this slice's own hidden results.
- R9: `done` is high for exactly one cycle, in the cycle where all owned outputs are readable on `out_rdata`. The outputs hold their values until the next pass overwrites them.
- R10: Input writes go to the fill buffer, and the pass reads the other buffer. An accepted `start` swaps the two. A write in the same cycle as an accepted `start` lands in the new fill buffer and does not affect the pass that is starting.
- R11: After reset the engine is idle, all strobes are low, and the hidden vector and output values read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a pass (accepted only while idle) |
| sync_go | input | 1 | All slices finished hidden phase |
| in_we | input | 1 | Input vector write enable |
| in_addr | input | clog2(NIN) | Input element index |
| in_data | input | 16 | Input element, Q8.8 |
| w_we | input | 1 | Weight write enable |
| w_addr | input | clog2(WTOT) | Weight address |
| w_data | input | 16 | Weight, Q8.8 |
| h_we | input | 1 | Hidden vector write enable (values of other slices) |
| h_addr | input | clog2(NHID) | Global hidden index |
| h_data | input | 16 | Hidden value, Q8.8 |
| out_raddr | input | clog2(NOUT/NSLICE) | Owned output index to read |
| out_rdata | output | 16 | Selected output value, Q8.8 |
| hid_valid | output | 1 | Hidden result strobe |
| hid_idx | output | clog2(NHID) | Global index of the strobed hidden value |
| hid_val | output | 16 | Strobed hidden value, Q8.8 |
| hid_done | output | 1 | Last owned hidden neuron finished |
| done | output | 1 | Pass finished, outputs valid |
| busy | output | 1 | Pass in progress, including the wait for sync |

## Verification
The interaction that matters most is an accepted `start` arriving in the same cycle as an input-buffer write. The bench issues both in one cycle: the write carries the first element of the next vector, and the rest of that vector is streamed in while the current pass runs. The bench then checks that the current pass's hidden and output results match a model built only from the earlier vector, and that the following pass matches a model that includes the same-cycle element. A second pairing places stray `start` and `sync_go` pulses inside the hidden phase. These are judged by the scoreboard, which flags any extra hidden strobe, and by checking that the engine stays parked until the real synchronization pulse.

// File: rtl/mlp_slice_pkg.sv
`timescale 1ns/1ps
package mlp_slice_pkg;
    localparam int DATA_W      = 16;
    localparam int ACC_W       = 24;
    localparam int FRAC        = 8;
    localparam int LUT_BITS    = 8;
    localparam int CLAMP_SHIFT = 4;
    localparam int CLAMP_W     = LUT_BITS + CLAMP_SHIFT;
    localparam int CL_MAX      = 2**(CLAMP_W-1) - 1;
    localparam int CL_MIN      = -(2**(CLAMP_W-1));
    localparam int HALF_Q      = 2**(FRAC-1);
    localparam int KNEE        = 2**CLAMP_SHIFT;

    typedef logic signed [DATA_W-1:0] fx_t;
    typedef logic signed [ACC_W-1:0]  acc_t;
    typedef enum logic [1:0] {PH_IDLE, PH_HID, PH_WAIT, PH_OUT} phase_t;

    localparam fx_t FX_ONE = fx_t'(2**FRAC);

    function automatic acc_t scaled_product(fx_t a, fx_t b);
        logic signed [2*DATA_W-1:0] p;
        p = a * b;
        return acc_t'(p >>> FRAC);
    endfunction

    function automatic acc_t sat_add(acc_t x, acc_t y);
        logic signed [ACC_W:0] s;
        s = x + y;
        if (s[ACC_W] != s[ACC_W-1])
            return s[ACC_W] ? {1'b1, {(ACC_W-1){1'b0}}} : {1'b0, {(ACC_W-1){1'b1}}};
        return acc_t'(s);
    endfunction

    function automatic int sig_point(int s);
        int mag;
        mag = (s < 0) ? -s : s;
        return HALF_Q + (HALF_Q * s) / (KNEE + mag);
    endfunction

    function automatic logic [LUT_BITS-1:0] lut_index(acc_t x);
        logic signed [CLAMP_W-1:0] c;
        if (x > acc_t'(CL_MAX))      c = CLAMP_W'(CL_MAX);
        else if (x < acc_t'(CL_MIN)) c = CLAMP_W'(CL_MIN);
        else                         c = x[CLAMP_W-1:0];
        return c[CLAMP_W-1:CLAMP_SHIFT] ^ {1'b1, {(LUT_BITS-1){1'b0}}};
    endfunction
endpackage

// File: rtl/mlp_sigmoid_lut.sv
`timescale 1ns/1ps
module mlp_sigmoid_lut
    import mlp_slice_pkg::*;
(
    input  acc_t x,
    output fx_t  y
);
    localparam int N = 2**LUT_BITS;

    fx_t rom [N];

    for (genvar i = 0; i < N; i++) begin : g_rom
        assign rom[i] = fx_t'(sig_point(i - N/2));
    end

    assign y = rom[lut_index(x)];
endmodule

// File: rtl/mlp_mac.sv
`timescale 1ns/1ps
module mlp_mac
    import mlp_slice_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic en,
    input  logic first,
    input  fx_t  act,
    input  fx_t  wt,
    output acc_t sum
);
    acc_t acc;
    acc_t prod;

    assign prod = scaled_product(act, wt);
    assign sum  = sat_add(first ? acc_t'(0) : acc, prod);

    always_ff @(posedge clk) begin
        if (rst)     acc <= acc_t'(0);
        else if (en) acc <= sum;
    end

    // R4: adding a non-negative term never lowers the running sum
    p_acc_no_wrap_pos_r4: assert property (@(posedge clk) disable iff (rst)
        (en && !first && !prod[ACC_W-1]) |=> (acc >= $past(acc)));
    // R4: adding a negative term never raises the running sum
    p_acc_no_wrap_neg_r4: assert property (@(posedge clk) disable iff (rst)
        (en && !first && prod[ACC_W-1]) |=> (acc <= $past(acc)));
endmodule

// File: rtl/mlp_input_bank.sv
`timescale 1ns/1ps
module mlp_input_bank
    import mlp_slice_pkg::*;
#(
    parameter int NIN  = 8,
    parameter int AW   = $clog2(NIN)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  fx_t           wdata,
    input  logic          swap,
    input  logic [AW-1:0] raddr,
    output fx_t           rdata
);
    fx_t  mem [2][NIN];
    logic fill;
    logic wbank;

    assign wbank = swap ? ~fill : fill;
    assign rdata = mem[~fill][raddr];

    always_ff @(posedge clk) begin
        if (rst)       fill <= 1'b0;
        else if (swap) fill <= ~fill;
    end

    always_ff @(posedge clk) begin
        if (we) mem[wbank][waddr] <= wdata;
    end
endmodule

// File: rtl/mlp_slice_engine.sv
`timescale 1ns/1ps
module mlp_slice_engine
    import mlp_slice_pkg::*;
#(
    parameter int NIN      = 8,
    parameter int NHID     = 8,
    parameter int NOUT     = 4,
    parameter int NSLICE   = 2,
    parameter int SLICE_ID = 1,
    localparam int OWN_H    = NHID / NSLICE,
    localparam int OWN_O    = NOUT / NSLICE,
    localparam int HFAN     = NIN + 1,
    localparam int OFAN     = NHID + 1,
    localparam int OUT_BASE = OWN_H * HFAN,
    localparam int WTOT     = OUT_BASE + OWN_O * OFAN,
    localparam int IN_AW    = $clog2(NIN),
    localparam int W_AW     = $clog2(WTOT),
    localparam int H_AW     = $clog2(NHID),
    localparam int O_AW     = (OWN_O > 1) ? $clog2(OWN_O) : 1
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            start,
    input  logic            sync_go,
    input  logic            in_we,
    input  logic [IN_AW-1:0] in_addr,
    input  logic [15:0]     in_data,
    input  logic            w_we,
    input  logic [W_AW-1:0] w_addr,
    input  logic [15:0]     w_data,
    input  logic            h_we,
    input  logic [H_AW-1:0] h_addr,
    input  logic [15:0]     h_data,
    input  logic [O_AW-1:0] out_raddr,
    output logic [15:0]     out_rdata,
    output logic            hid_valid,
    output logic [H_AW-1:0] hid_idx,
    output logic [15:0]     hid_val,
    output logic            hid_done,
    output logic            done,
    output logic            busy
);
    localparam int HID_BASE = SLICE_ID * OWN_H;
    localparam int MAX_NEU  = (OWN_H > OWN_O) ? OWN_H : OWN_O;
    localparam int MAX_FAN  = (NIN > NHID) ? NIN : NHID;
    localparam int NEU_W    = $clog2(MAX_NEU + 1);
    localparam int TERM_W   = $clog2(MAX_FAN + 1);

    phase_t            ph;
    logic [NEU_W-1:0]  neu;
    logic [TERM_W-1:0] term;
    fx_t               wmem [WTOT];
    fx_t               hvec [NHID];
    fx_t               outs [OWN_O];

    logic start_ok, in_hid, in_out, last_term, last_neu, first;
    fx_t  act, wt, in_rd, sig;
    acc_t sum;

    assign start_ok  = start && (ph == PH_IDLE);
    assign in_hid    = (ph == PH_HID);
    assign in_out    = (ph == PH_OUT);
    assign first     = (term == '0);
    assign last_term = in_hid ? (term == TERM_W'(NIN)) : (term == TERM_W'(NHID));
    assign last_neu  = in_hid ? (neu == NEU_W'(OWN_H - 1)) : (neu == NEU_W'(OWN_O - 1));
    assign busy      = (ph != PH_IDLE);
    assign out_rdata = outs[out_raddr];

    mlp_input_bank #(.NIN(NIN), .AW(IN_AW)) u_bank (
        .clk   (clk),
        .rst   (rst),
        .we    (in_we),
        .waddr (in_addr),
        .wdata (fx_t'(in_data)),
        .swap  (start_ok),
        .raddr (IN_AW'(term - 1'b1)),
        .rdata (in_rd)
    );

    always_comb begin
        int a;
        if (in_out) a = OUT_BASE + int'(neu) * OFAN + int'(term);
        else        a = int'(neu) * HFAN + int'(term);
        wt = wmem[W_AW'(a)];
        if (first)       act = FX_ONE;
        else if (in_hid) act = in_rd;
        else             act = hvec[H_AW'(term - 1'b1)];
    end

    mlp_mac u_mac (
        .clk   (clk),
        .rst   (rst),
        .en    (in_hid || in_out),
        .first (first),
        .act   (act),
        .wt    (wt),
        .sum   (sum)
    );

    mlp_sigmoid_lut u_lut (
        .x (sum),
        .y (sig)
    );

    always_ff @(posedge clk) begin
        if (w_we && (int'(w_addr) < WTOT)) wmem[w_addr] <= fx_t'(w_data);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ph        <= PH_IDLE;
            neu       <= '0;
            term      <= '0;
            hid_valid <= 1'b0;
            hid_idx   <= '0;
            hid_val   <= '0;
            hid_done  <= 1'b0;
            done      <= 1'b0;
            for (int i = 0; i < NHID; i++)  hvec[i] <= '0;
            for (int i = 0; i < OWN_O; i++) outs[i] <= '0;
        end else begin
            hid_valid <= 1'b0;
            hid_done  <= 1'b0;
            done      <= 1'b0;
            if (h_we) hvec[h_addr] <= fx_t'(h_data);
            unique case (ph)
                PH_IDLE: begin
                    if (start_ok) begin
                        ph   <= PH_HID;
                        neu  <= '0;
                        term <= '0;
                    end
                end
                PH_HID: begin
                    if (last_term) begin
                        hvec[H_AW'(HID_BASE + int'(neu))] <= sig;
                        hid_valid <= 1'b1;
                        hid_idx   <= H_AW'(HID_BASE + int'(neu));
                        hid_val   <= sig;
                        term      <= '0;
                        if (last_neu) begin
                            neu      <= '0;
                            ph       <= PH_WAIT;
                            hid_done <= 1'b1;
                        end else begin
                            neu <= neu + 1'b1;
                        end
                    end else begin
                        term <= term + 1'b1;
                    end
                end
                PH_WAIT: begin
                    if (sync_go) ph <= PH_OUT;
                end
                PH_OUT: begin
                    if (last_term) begin
                        outs[O_AW'(neu)] <= sig;
                        term <= '0;
                        if (last_neu) begin
                            neu  <= '0;
                            ph   <= PH_IDLE;
                            done <= 1'b1;
                        end else begin
                            neu <= neu + 1'b1;
                        end
                    end else begin
                        term <= term + 1'b1;
                    end
                end
                default: ph <= PH_IDLE;
            endcase
        end
    end

    // R1: a start seen mid-pass must not rewind the neuron or term counters
    p_start_ignored_r1: assert property (@(posedge clk) disable iff (rst)
        (in_hid && start && !(last_term && last_neu)) |=> (neu != '0 || term != '0));
    // R6: published hidden indices stay inside the owned range
    p_hid_idx_owned_r6: assert property (@(posedge clk) disable iff (rst)
        hid_valid |-> (int'(hid_idx) >= HID_BASE && int'(hid_idx) < HID_BASE + OWN_H));
    // R6: the end-of-phase pulse coincides with a hidden strobe
    p_hid_done_strobe_r6: assert property (@(posedge clk) disable iff (rst)
        hid_done |-> hid_valid);
    // R7: the engine stays parked until sync arrives
    p_wait_holds_r7: assert property (@(posedge clk) disable iff (rst)
        (ph == PH_WAIT && !sync_go) |=> (ph == PH_WAIT));
    // R7: output phase is entered only on sync
    p_out_entry_r7: assert property (@(posedge clk) disable iff (rst)
        (in_out && $past(ph) == PH_WAIT) |-> $past(sync_go));
    // R9: completion pulse lasts one cycle
    p_done_single_r9: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);
endmodule

// File: tb/sim_mlp_slice_engine.sv
`timescale 1ns/1ps
module sim_mlp_slice_engine;
    localparam int NIN = 8, NHID = 8, OWN_H = 4, OWN_O = 2;
    localparam int HFAN = NIN + 1, OFAN = NHID + 1, OUT_BASE = OWN_H * HFAN;
    localparam int WTOT = OUT_BASE + OWN_O * OFAN;
    localparam int HBASE = 4;

    logic clk = 1'b0;
    logic rst, start, sync_go, in_we, w_we, h_we;
    logic [2:0] in_addr;
    logic [15:0] in_data, w_data, h_data, out_rdata, hid_val;
    logic [5:0] w_addr;
    logic [2:0] h_addr, hid_idx;
    logic [0:0] out_raddr;
    logic hid_valid, hid_done, done, busy;

    always #2.5 clk = ~clk;

    mlp_slice_engine u0 (
        .clk(clk), .rst(rst), .start(start), .sync_go(sync_go),
        .in_we(in_we), .in_addr(in_addr), .in_data(in_data),
        .w_we(w_we), .w_addr(w_addr), .w_data(w_data),
        .h_we(h_we), .h_addr(h_addr), .h_data(h_data),
        .out_raddr(out_raddr), .out_rdata(out_rdata),
        .hid_valid(hid_valid), .hid_idx(hid_idx), .hid_val(hid_val),
        .hid_done(hid_done), .done(done), .busy(busy)
    );

    typedef struct { int idx; int val; } hexp_t;
    hexp_t hq[$];
    int checks = 0, fails = 0, hcount = 0;
    int wm [WTOT];
    int hmodel [NHID];
    int exp_out [OWN_O];
    int prev_out [OWN_O];
    int va [NIN], vb [NIN], vc [NIN];

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int b_prod(int a, int w);
        longint p;
        p = longint'(a) * longint'(w);
        return int'(p >>> 8);
    endfunction

    function automatic int b_sat(longint s);
        if (s > 8388607)  return 8388607;
        if (s < -8388608) return -8388608;
        return int'(s);
    endfunction

    function automatic int b_sig(int acc);
        int c, s, m;
        c = (acc > 2047) ? 2047 : ((acc < -2048) ? -2048 : acc);
        s = c >>> 4;
        m = (s < 0) ? -s : s;
        return 128 + (128 * s) / (16 + m);
    endfunction

    function automatic int b_neuron(int base, int fan, int acts [NHID]);
        int acc;
        acc = b_sat(longint'(b_prod(256, wm[base])));
        for (int k = 1; k < fan; k++)
            acc = b_sat(longint'(acc) + longint'(b_prod(acts[k-1], wm[base+k])));
        return b_sig(acc);
    endfunction

    // driver side of the scoreboard: push expected hidden strobes, compute outputs
    task automatic compute_run(input int vin [NIN]);
        int acts [NHID];
        hexp_t e;
        for (int i = 0; i < NHID; i++) acts[i] = (i < NIN) ? vin[i] : 0;
        for (int h = 0; h < OWN_H; h++) begin
            hmodel[HBASE+h] = b_neuron(h * HFAN, HFAN, acts);
            e.idx = HBASE + h;
            e.val = hmodel[HBASE+h];
            hq.push_back(e);
        end
        for (int o = 0; o < OWN_O; o++)
            exp_out[o] = b_neuron(OUT_BASE + o * OFAN, OFAN, hmodel);
    endtask

    // monitor side of the scoreboard
    always @(negedge clk) begin
        if (!rst && hid_valid) begin
            hexp_t e;
            hcount++;
            checks++;
            if (hq.size() == 0) begin
                fails++;
                $display("FAIL R1 R6 unexpected hidden strobe actual=%0d expected=%0d", hid_idx, -1);
            end else begin
                e = hq.pop_front();
                if (int'(hid_idx) != e.idx || int'($signed(hid_val)) != e.val) begin
                    fails++;
                    $display("FAIL R2 R3 R4 R5 R6 hidden idx %0d actual=%0d expected=%0d (idx exp %0d)",
                             hid_idx, $signed(hid_val), e.val, e.idx);
                end
            end
        end
    end

    task automatic write_w(input int a, input int v);
        @(posedge clk); #1; w_we = 1; w_addr = 6'(a); w_data = 16'(v); wm[a] = v;
        @(posedge clk); #1; w_we = 0;
    endtask

    task automatic write_in(input int a, input int v);
        @(posedge clk); #1; in_we = 1; in_addr = 3'(a); in_data = 16'(v);
        @(posedge clk); #1; in_we = 0;
    endtask

    task automatic write_h(input int a, input int v);
        @(posedge clk); #1; h_we = 1; h_addr = 3'(a); h_data = 16'(v); hmodel[a] = v;
        @(posedge clk); #1; h_we = 0;
    endtask

    task automatic pulse_start(input bit with_wr, input int a, input int v);
        @(posedge clk); #1; start = 1;
        if (with_wr) begin in_we = 1; in_addr = 3'(a); in_data = 16'(v); end
        @(posedge clk); #1; start = 0; in_we = 0;
    endtask

    task automatic pulse_sync();
        @(posedge clk); #1; sync_go = 1;
        @(posedge clk); #1; sync_go = 0;
    endtask

    task automatic wait_evt(input bit which_done, output bit got);
        got = 0;
        for (int i = 0; i < 2000; i++) begin
            @(negedge clk);
            if (which_done ? done : hid_done) begin got = 1; return; end
        end
    endtask

    task automatic check_outs(input string req, input int exp [OWN_O]);
        for (int o = 0; o < OWN_O; o++) begin
            out_raddr = 1'(o); #0.5;
            chk(int'($signed(out_rdata)) == exp[o], req, int'($signed(out_rdata)), exp[o]);
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        bit got;
        int zero [OWN_O];
        rst = 1; start = 0; sync_go = 0; in_we = 0; w_we = 0; h_we = 0;
        in_addr = 0; in_data = 0; w_addr = 0; w_data = 0; h_addr = 0; h_data = 0; out_raddr = 0;
        for (int o = 0; o < OWN_O; o++) zero[o] = 0;
        repeat (3) @(posedge clk); #1 rst = 0;
        @(negedge clk);
        // R11 reset state
        chk(!busy, "R11 busy", busy, 0);
        chk(!done && !hid_done, "R11 done", done, 0);
        chk(!hid_valid, "R11 hid_valid", hid_valid, 0);
        check_outs("R11 outputs", zero);

        for (int a = 0; a < WTOT; a++) write_w(a, (((a * 53) % 97) - 48) * 6);
        for (int j = 0; j < HBASE; j++) write_h(j, 30 * j - 40);
        for (int i = 0; i < NIN; i++) begin
            va[i] = i * 45 - 150; vb[i] = 200 - i * 37; vc[i] = 32767;
        end
        for (int i = 0; i < NIN; i++) write_in(i, va[i]);

        // run A: start with a same-cycle write of next vector's element 0 (R10)
        compute_run(va);
        hcount = 0;
        pulse_start(1, 0, vb[0]);
        repeat (4) @(posedge clk);
        pulse_sync();                     // R7: ignored during hidden phase
        repeat (8) @(posedge clk);
        pulse_start(0, 0, 0);             // R1: ignored while busy
        for (int i = 1; i < NIN; i++) write_in(i, vb[i]);
        wait_evt(0, got);
        chk(got, "R6 hid_done seen", got, 1);
        repeat (6) @(negedge clk);
        chk(hcount == OWN_H, "R1 R6 hidden strobe count", hcount, OWN_H);
        chk(busy && !done, "R7 parked until sync", done, 0);
        pulse_sync();
        wait_evt(1, got);
        chk(got, "R9 done seen", got, 1);
        check_outs("R8 R2 run A outputs", exp_out);
        @(negedge clk);
        chk(!done, "R9 done single cycle", done, 0);
        chk(!busy, "R9 idle after done", busy, 1);
        for (int o = 0; o < OWN_O; o++) prev_out[o] = exp_out[o];

        // run B: vector from buffer filled during run A
        compute_run(vb);
        hcount = 0;
        pulse_start(0, 0, 0);
        for (int i = 0; i < NIN; i++) write_in(i, vc[i]);
        wait_evt(0, got);
        chk(got, "R6 hid_done run B", got, 1);
        @(negedge clk);
        chk(hq.size() == 0, "R10 R6 run B strobes consumed", hq.size(), 0);
        check_outs("R9 outputs held", prev_out);
        pulse_sync();
        wait_evt(1, got);
        chk(got, "R9 done run B", got, 1);
        check_outs("R10 R8 run B outputs", exp_out);

        // run C: saturation in both directions (R4)
        write_w(0, 0);
        for (int k = 1; k < HFAN; k++) write_w(k, (k <= 3) ? 32767 : 0);
        write_w(HFAN, 0);
        for (int k = 1; k < HFAN; k++) write_w(HFAN + k, (k <= 3) ? -32768 : 0);
        compute_run(vc);
        chk(hmodel[HBASE] == 241 && hmodel[HBASE+1] == 15, "R4 model saturation", hmodel[HBASE], 241);
        hcount = 0;
        pulse_start(0, 0, 0);
        wait_evt(0, got);
        chk(got, "R4 hid_done run C", got, 1);
        @(negedge clk);
        chk(hcount == OWN_H && hq.size() == 0, "R4 run C strobes", hcount, OWN_H);
        pulse_sync();
        wait_evt(1, got);
        chk(got, "R4 done run C", got, 1);
        check_outs("R4 R8 run C outputs", exp_out);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule